// File: doc/BRIEF.md
# Delta-Modulation Sample Playback Channel

This block plays back 1-bit delta-coded audio stored in memory. A 6-bit level counter moves up or down by one step for every coded bit, and the bits are consumed least significant first from an 8-bit shifter. A programmable timer sets how long each bit lasts. An autonomous fetcher refills the shifter over a request/valid read port as soon as the shifter runs dry. It walks a block whose start and length are derived from two byte registers. When the block is exhausted, the fetcher either restarts it or stops the channel and optionally raises an interrupt.

Software programs the channel through four byte registers and a control/status pair. The four registers set the mode and rate, load the output level directly, set the block start, and set the block size. The control write starts or stops playback, and the status word reports the running and interrupt flags. The 7-bit output is the level counter doubled plus a separately held low bit, ready for a downstream mixer. Timer ticks arrive on a one-cycle enable, so the channel can run from a fast core clock.

Top module: `dpcm_channel`

## Requirements
- R1: After reset the output is 0, the status word is 0x00, no memory request is raised, the interrupt is low, and rate index 0 is selected.
- R2: With playback running, output steps occur once every P timer ticks, where P is the rate table entry chosen by mode-register bits [3:0] (first table: 428 380 340 320 286 254 226 214 190 160 142 128 106 84 72 54 for indices 0..15); clock cycles without a tick are not counted.
- R3: On each bit period with the shifter holding data, a coded 1 raises the 6-bit level unless it is 63, a coded 0 lowers it unless it is 0, and the shifter advances one bit, LSB first.
- R4: The output equals level*2 plus the separate low bit; bit playback never alters that low bit.
- R5: A write to register select 1 sets the level to data[6:1] and the low bit to data[0] at once, without stopping or restarting playback.
- R6: A control write with bit 4 set while idle starts playback at address 0xC000 | (addr_reg << 6) for (len_reg*16)+1 bytes and clears the interrupt; the same write while running has no effect.
- R7: Whenever the shifter is empty and the channel runs, one read request is held until valid; each accepted byte advances the address by one, wrapping 0xFFFF to 0x8000.
- R8: Writing the address register (select 2) or length register (select 3) during playback does not change the block in progress.
- R9: When the last byte is accepted and mode bit 6 (loop) is set, the start address and length are reloaded and the channel keeps running.
- R10: When the last byte is accepted without loop, the channel goes idle and the interrupt is set only when mode bits [7:6] equal 2'b10.
- R11: A control write with bit 4 clear stops the channel and drops any pending request on the next cycle.
- R12: The status word carries the interrupt flag in bit 7 and the running flag in bit 4, with all other bits 0; irq_o mirrors bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One-cycle enable per timer tick |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 mode/rate, 1 direct level, 2 block address, 3 block size |
| reg_wdata | input | 8 | Register write data |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data; bit 4 runs or stops playback |
| mem_req | output | 1 | Read request, held until mem_valid |
| mem_addr | output | 16 | Read address |
| mem_valid | input | 1 | Read data valid for the pending request |
| mem_rdata | input | 8 | Read data |
| sample_o | output | 7 | Channel output level |
| status_o | output | 8 | Interrupt in bit 7, running in bit 4 |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench builds the channel with its default parameter, so the first rate table is active. This lets measured bit intervals be compared directly against its entries. Driving the tick every clock at the fastest rate index keeps a 65-byte block short enough to follow byte by byte across the 0xFFFF to 0x8000 wrap. A phase with the tick at half rate shows that the timer counts ticks and not clocks. The slowest index confirms the longest period.

// File: rtl/dpcm_channel.sv
module dpcm_channel #(
  parameter bit ALT_STD = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_tick,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_valid,
  input  logic [7:0]  mem_rdata,
  output logic [6:0]  sample_o,
  output logic [7:0]  status_o,
  output logic        irq_o
);

  function automatic logic [8:0] period_of(input logic [3:0] idx);
    logic [8:0] p;
    if (!ALT_STD) begin
      case (idx)
        4'd0:  p = 9'd428;  4'd1:  p = 9'd380;  4'd2:  p = 9'd340;  4'd3:  p = 9'd320;
        4'd4:  p = 9'd286;  4'd5:  p = 9'd254;  4'd6:  p = 9'd226;  4'd7:  p = 9'd214;
        4'd8:  p = 9'd190;  4'd9:  p = 9'd160;  4'd10: p = 9'd142;  4'd11: p = 9'd128;
        4'd12: p = 9'd106;  4'd13: p = 9'd84;   4'd14: p = 9'd72;   default: p = 9'd54;
      endcase
    end else begin
      case (idx)
        4'd0:  p = 9'd398;  4'd1:  p = 9'd354;  4'd2:  p = 9'd316;  4'd3:  p = 9'd298;
        4'd4:  p = 9'd276;  4'd5:  p = 9'd236;  4'd6:  p = 9'd210;  4'd7:  p = 9'd198;
        4'd8:  p = 9'd176;  4'd9:  p = 9'd148;  4'd10: p = 9'd132;  4'd11: p = 9'd118;
        4'd12: p = 9'd98;   4'd13: p = 9'd78;   4'd14: p = 9'd66;   default: p = 9'd50;
      endcase
    end
    return p;
  endfunction

  logic [1:0]  mode_q;
  logic [3:0]  rate_q;
  logic [8:0]  timer_q;
  logic [5:0]  level_q;
  logic        lsb_q;
  logic [7:0]  shreg_q;
  logic [3:0]  bits_q;
  logic [15:0] addr_q;
  logic [11:0] remain_q;
  logic [7:0]  areg_q, lreg_q;
  logic        run_q, irq_q, req_q;

  wire wr_mode  = reg_we && reg_sel == 2'd0;
  wire wr_level = reg_we && reg_sel == 2'd1;
  wire [8:0] new_p = period_of(reg_wdata[3:0]);
  wire [8:0] cur_p = period_of(rate_q);
  wire expire   = cpu_tick && timer_q == 9'd0;
  wire start    = ctl_we && ctl_wdata[4] && !run_q;
  wire stop     = ctl_we && !ctl_wdata[4];
  wire take     = req_q && mem_valid;
  wire last     = remain_q == 12'd1;
  wire [15:0] base_addr = 16'hC000 | {2'b00, areg_q, 6'd0};
  wire [11:0] base_len  = {lreg_q, 4'd0} + 12'd1;
  wire [15:0] next_addr = (addr_q == 16'hFFFF) ? 16'h8000 : addr_q + 16'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 2'd0;
      rate_q  <= 4'd0;
      timer_q <= period_of(4'd0) - 9'd1;
      areg_q  <= 8'd0;
      lreg_q  <= 8'd0;
    end else begin
      if (reg_we && reg_sel == 2'd2) areg_q <= reg_wdata;
      if (reg_we && reg_sel == 2'd3) lreg_q <= reg_wdata;
      if (wr_mode) begin
        mode_q <= reg_wdata[7:6];
        rate_q <= reg_wdata[3:0];
        if (timer_q > new_p - 9'd1) timer_q <= new_p - 9'd1;
      end else if (cpu_tick) begin
        timer_q <= (timer_q == 9'd0) ? cur_p - 9'd1 : timer_q - 9'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 6'd0;
      lsb_q   <= 1'b0;
      shreg_q <= 8'd0;
      bits_q  <= 4'd0;
    end else begin
      if (take) begin
        shreg_q <= mem_rdata;
        bits_q  <= 4'd8;
      end else if (expire && bits_q != 4'd0) begin
        shreg_q <= shreg_q >> 1;
        bits_q  <= bits_q - 4'd1;
      end
      if (wr_level) begin
        level_q <= reg_wdata[6:1];
        lsb_q   <= reg_wdata[0];
      end else if (expire && bits_q != 4'd0) begin
        if (shreg_q[0] && level_q != 6'd63) level_q <= level_q + 6'd1;
        else if (!shreg_q[0] && level_q != 6'd0) level_q <= level_q - 6'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= 16'd0;
      remain_q <= 12'd0;
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (start) begin
        addr_q   <= base_addr;
        remain_q <= base_len;
        run_q    <= 1'b1;
        irq_q    <= 1'b0;
      end else if (stop) begin
        run_q <= 1'b0;
      end else if (take) begin
        if (last && mode_q[0]) begin
          addr_q   <= base_addr;
          remain_q <= base_len;
        end else begin
          addr_q   <= next_addr;
          remain_q <= remain_q - 12'd1;
          if (last) begin
            run_q <= 1'b0;
            irq_q <= mode_q == 2'b10;
          end
        end
      end
      if (stop || take) req_q <= 1'b0;
      else if (run_q && bits_q == 4'd0) req_q <= 1'b1;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign sample_o = {level_q, lsb_q};
  assign status_o = {irq_q, 2'b00, run_q, 4'b0000};
  assign irq_o    = irq_q;

endmodule

// File: rtl/dpcm_channel_chk.sv
module dpcm_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [7:0]  reg_wdata,
  input logic        ctl_we,
  input logic [7:0]  ctl_wdata,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_valid,
  input logic [6:0]  sample_o,
  input logic [7:0]  status_o,
  input logic        irq_o
);

  p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel == 2'd1) |=>
      ((sample_o[6:1] - $past(sample_o[6:1])) == 6'd0 ||
       (sample_o[6:1] - $past(sample_o[6:1])) == 6'd1 ||
       (sample_o[6:1] - $past(sample_o[6:1])) == 6'h3F));

  p_lsb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel == 2'd1) |=> $stable(sample_o[0]));

  p_direct_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1) |=> sample_o == $past(reg_wdata[6:0]));

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[4] && !status_o[4]) |=> status_o[4] && !irq_o);

  p_req_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> status_o[4]);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid && !(ctl_we && !ctl_wdata[4])) |=> mem_req && $stable(mem_addr));

  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[4]) |=> !status_o[4] && !mem_req);

  p_status_shape_r12: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00 && status_o[3:0] == 4'b0000 && status_o[7] == irq_o);

endmodule

bind dpcm_channel dpcm_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .sample_o(sample_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/dpcm_channel_tb.sv
module dpcm_channel_tb;
  logic clk = 0, rst_n = 0, cpu_tick = 1'b1;
  logic reg_we = 0, ctl_we = 0, mem_valid = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, ctl_wdata = 0, mem_rdata = 0;
  logic mem_req, irq_o;
  logic [15:0] mem_addr;
  logic [6:0] sample_o;
  logic [7:0] status_o;

  int total = 0, fails = 0, cyc = 0;
  logic half_tick = 0;
  logic [7:0] fill = 8'h00;
  int nfetch = 0;
  logic [15:0] flog [0:127];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpcm_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .sample_o(sample_o),
    .status_o(status_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    cpu_tick <= half_tick ? ~cpu_tick : 1'b1;
    if (mem_req && !mem_valid) begin
      mem_valid <= 1'b1;
      mem_rdata <= fill;
      if (nfetch < 128) flog[nfetch] <= mem_addr;
      nfetch <= nfetch + 1;
    end else begin
      mem_valid <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wait_change(output int at);
    logic [6:0] prev;
    prev = sample_o;
    at = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (sample_o != prev) begin at = cyc; break; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0] rate;
    logic [7:0] data;
    logic [8:0] period;
    logic [6:0] final_out;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{4'd15, 8'hFF, 9'd54,  7'd80},
    '{4'd14, 8'h00, 9'd72,  7'd48},
    '{4'd9,  8'h55, 9'd160, 7'd64},
    '{4'd0,  8'hFF, 9'd428, 7'd80}
  };

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 output", sample_o, 0);
    chk("R1 status", status_o, 8'h00);
    chk("R1 request", mem_req, 0);
    chk("R1 irq", irq_o, 0);

    // R2 R3 R4: table of rate, data, period and final level
    foreach (VECS[i]) begin
      wr(2'd0, {4'h0, VECS[i].rate});
      wr(2'd1, 8'h40);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
      fill = VECS[i].data;
      ctl(8'h10);
      wait_change(t1);
      wait_change(t2);
      chk("R2 period", t2 - t1, VECS[i].period);
      for (int k = 0; k < 6; k++) wait_change(t1);
      chk("R3 final output", sample_o, VECS[i].final_out);
    end
    chk("R10 no irq in mode 0", status_o, 8'h00);

    // R3 saturation at both ends, R4 low bit kept
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h7E); fill = 8'hFF; ctl(8'h10); idle(600);
    chk("R3 saturate high", sample_o, 7'h7E);
    wr(2'd1, 8'h01); fill = 8'h00; ctl(8'h10); idle(600);
    chk("R3 saturate low R4 lsb", sample_o, 7'h01);

    // R5 direct load mid-byte
    wr(2'd1, 8'h14); fill = 8'hFF; ctl(8'h10);
    wait_change(t1);
    chk("R5 first step", sample_o, 7'h16);
    wr(2'd1, 8'h20);
    chk("R5 load value", sample_o, 7'h20);
    idle(600);
    chk("R5 playback continued", sample_o, 7'd46);

    // R2 tick enable at half rate
    half_tick = 1;
    wr(2'd1, 8'h40); ctl(8'h10);
    wait_change(t1); wait_change(t2);
    chk("R2 ticks not clocks", t2 - t1, 108);
    idle(1200);
    half_tick = 0;

    // R7 wrap, R8 register writes ignored, R6 restart ignored, R10 irq
    wr(2'd0, 8'h8F); wr(2'd2, 8'hFF); wr(2'd3, 8'h04);
    fill = 8'hAA; nfetch = 0;
    ctl(8'h10);
    while (nfetch < 10) @(negedge clk);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    ctl(8'h10);
    for (int k = 0; k < 40000 && status_o[4]; k++) @(negedge clk);
    chk("R6 R8 byte count", nfetch, 65);
    chk("R6 first address", flog[0], 16'hFFC0);
    chk("R8 address after writes", flog[12], 16'hFFCC);
    chk("R7 top address", flog[63], 16'hFFFF);
    chk("R7 wrap address", flog[64], 16'h8000);
    chk("R10 irq set R12", status_o, 8'h80);
    chk("R12 irq pin", irq_o, 1);
    ctl(8'h10);
    chk("R6 start clears irq R12", status_o, 8'h10);
    for (int k = 0; k < 2000 && status_o[4]; k++) @(negedge clk);
    idle(600);

    // R9 loop, R11 stop
    wr(2'd0, 8'h4F); wr(2'd2, 8'h01);
    nfetch = 0;
    ctl(8'h10);
    while (nfetch < 3) @(negedge clk);
    chk("R9 loop address a", flog[0], 16'hC040);
    chk("R9 loop address b", flog[2], 16'hC040);
    chk("R9 still running", status_o[4], 1);
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h00;
    @(negedge clk); ctl_we = 0;
    chk("R11 stopped", status_o, 8'h00);
    chk("R11 request dropped", mem_req, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule